// File: doc/BRIEF.md
# Drift-Tube TDC Hit Buffer with Trigger Window Matching

This block is the digital back end of a multi-channel drift-tube time-to-digital converter. Each channel reports a hit with a 5-bit fine code taken from an external interpolator that splits one crossing period into 32 bins. The hit is stamped with the crossing counter that is current when it arrives. Hits wait in per-channel latches and then go into a shared ring buffer, one hit per cycle. The buffer keeps the most recent hits, so older entries expire as new ones arrive.

When a trigger accept arrives, the block records the current crossing count and walks the whole buffer from the oldest entry to the newest. It emits only those hits whose crossing stamp lies inside a window placed behind the trigger. The window has two settings. `win_offset` is the age in crossings of the oldest crossing in the window. `win_width` is the number of crossings the window spans. All time arithmetic wraps with the coarse counter.

The output of each trigger is a packet: a header word with the event number, one data word per matched hit, and a trailer word with the hit count. Each word is shifted out MSB first on a single serial line with a frame strobe. Every word carries a 2-bit chip identifier, so up to four such blocks can share one link.

Top module: `tdc_match_core`

## Requirements
- R1: After reset, `ser_frame` stays low until a trigger is accepted, and the first packet after reset carries event number 0.
- R2: A stored hit with coarse stamp H is reported for a trigger taken at crossing T exactly when ((H + win_offset − T) mod 2^CW) < win_width. This includes windows that wrap through zero. Reading a hit does not remove it from the buffer.
- R3: A hit whose age (T − H) mod 2^CW is larger than win_offset (expired), or smaller than win_offset − win_width + 1 (too recent), is not reported. A width of 0 reports nothing.
- R4: Each word is WORD_W = 4 + CHW + CW + 5 bits wide. Bits [WORD_W−1:WORD_W−2] hold the kind: 2'b10 for the header, 2'b00 for data and 2'b11 for the trailer. A data word below the chip field holds channel (CHW bits), then coarse stamp (CW bits), then fine code (5 bits). Header and trailer hold a zero-extended payload in the low WORD_W−4 bits. A packet is one header, then the data words, then one trailer whose payload is the number of data words.
- R5: Bits [WORD_W−3:WORD_W−4] of every word equal `chip_id`.
- R6: The event number in the header advances by one for each accepted trigger and wraps at 2^EVT_W.
- R7: Hits that arrive in the same cycle on several channels are stored one per cycle in ascending channel order. Data words leave in storage order, oldest first.
- R8: A hit on a channel whose previous hit is still waiting to be stored is dropped. The waiting hit is kept.
- R9: A trigger that arrives while a packet is being produced is ignored: it produces no packet and does not advance the event number.
- R10: Hits that arrive while a packet is being produced are held and stored after the packet ends, so they are visible to later triggers.
- R11: The buffer keeps the DEPTH most recently stored hits. Storing a further hit overwrites the oldest one.
- R12: Each word occupies exactly WORD_W consecutive cycles with `ser_frame` high, MSB first on `ser_data`. At least one cycle with `ser_frame` low separates two words.
- R13: The fine code of a hit is reported unchanged in its data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_count | input | CW | Current crossing counter value |
| hit_valid | input | NCH | One hit strobe per channel |
| hit_fine | input | NCH*5 | Fine code per channel, channel c at bits [5c+4:5c] |
| trig_accept | input | 1 | Trigger accept strobe |
| chip_id | input | 2 | Identifier placed in every output word |
| win_offset | input | CW | Age in crossings of the oldest crossing in the window |
| win_width | input | CW | Window span in crossings |
| ser_data | output | 1 | Serial word data, MSB first |
| ser_frame | output | 1 | High during each bit of an output word |

## Verification
The bench builds the block with 24 channels, a 6-bit coarse counter, an 8-entry buffer and an 8-bit event number. The short counter lets windows that wrap through zero be reached with only a few crossing values. The small buffer lets ten hits show the oldest-first overwrite. A table of hit and trigger crossings with offset and width settings probes both window edges, expired hits, zero width and wrap. Directed tests then cover same-cycle channel ordering, triggers and hits that arrive during a packet, and buffer overflow.

// File: rtl/tdc_match_pkg.sv
package tdc_match_pkg;

  // Kind code in the two top bits of every output word
  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_HEAD = 2'b10,
    KIND_TAIL = 2'b11
  } word_kind_e;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_HEAD,
    SC_SCAN,
    SC_TAIL
  } scan_state_e;

endpackage

// File: rtl/tdc_hit_capture.sv
// Per-channel hit latches plus lowest-index-first write selection.
module tdc_hit_capture #(
  parameter int NCH = 24,
  parameter int CW  = 12,
  parameter int FW  = 5,
  parameter int CHW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_valid,
  input  logic [NCH*FW-1:0] hit_fine,
  input  logic [CW-1:0]     bx,
  input  logic              stall,
  output logic              wr_en,
  output logic [CHW-1:0]    wr_chan,
  output logic [CW-1:0]     wr_coarse,
  output logic [FW-1:0]     wr_fine,
  output logic [NCH-1:0]    pend_o,
  output logic [NCH-1:0]    grant_o
);

  logic [NCH-1:0] pend;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] ld;
  logic [CW-1:0]  pc [NCH];
  logic [FW-1:0]  pf [NCH];

  function automatic logic [NCH-1:0] pick_lowest(input logic [NCH-1:0] v);
    return v & (~v + NCH'(1));
  endfunction

  assign grant = stall ? '0 : pick_lowest(pend);

  // A new hit is taken when the latch is free or is being emptied now
  for (genvar g = 0; g < NCH; g++) begin : g_ld
    assign ld[g] = hit_valid[g] && (!pend[g] || grant[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NCH; i++) begin
        pc[i] <= '0;
        pf[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ld[i]) begin
          pend[i] <= 1'b1;
          pc[i]   <= bx;
          pf[i]   <= hit_fine[i*FW +: FW];
        end else if (grant[i]) begin
          pend[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    wr_chan   = '0;
    wr_coarse = '0;
    wr_fine   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (grant[i]) begin
        wr_chan   = CHW'(i);
        wr_coarse = pc[i];
        wr_fine   = pf[i];
      end
    end
  end

  assign wr_en   = |grant;
  assign pend_o  = pend;
  assign grant_o = grant;

endmodule

// File: rtl/tdc_l1_ring.sv
// Circular hit store; a write always lands on the oldest slot.
module tdc_l1_ring #(
  parameter int DEPTH = 32,
  parameter int CHW   = 5,
  parameter int CW    = 12,
  parameter int FW    = 5,
  parameter int AW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] w_chan,
  input  logic [CW-1:0]  w_coarse,
  input  logic [FW-1:0]  w_fine,
  input  logic [AW-1:0]  rd_idx,
  output logic           rd_vld,
  output logic [CHW-1:0] rd_chan,
  output logic [CW-1:0]  rd_coarse,
  output logic [FW-1:0]  rd_fine,
  output logic [AW-1:0]  wptr_o
);

  logic [CHW-1:0]   m_chan   [DEPTH];
  logic [CW-1:0]    m_coarse [DEPTH];
  logic [FW-1:0]    m_fine   [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      wptr <= '0;
    end else if (we) begin
      vld[wptr] <= 1'b1;
      wptr      <= wptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      m_chan[wptr]   <= w_chan;
      m_coarse[wptr] <= w_coarse;
      m_fine[wptr]   <= w_fine;
    end
  end

  assign rd_vld    = vld[rd_idx];
  assign rd_chan   = m_chan[rd_idx];
  assign rd_coarse = m_coarse[rd_idx];
  assign rd_fine   = m_fine[rd_idx];
  assign wptr_o    = wptr;

endmodule

// File: rtl/tdc_window_scan.sv
// Trigger matching: header, oldest-to-newest scan of every slot, trailer.
module tdc_window_scan
  import tdc_match_pkg::*;
#(
  parameter int CW     = 12,
  parameter int CHW    = 5,
  parameter int FW     = 5,
  parameter int AW     = 5,
  parameter int DEPTH  = 32,
  parameter int EVT_W  = 12,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [CW-1:0]     trig_bx,
  input  logic [1:0]        chip,
  input  logic [CW-1:0]     win_offset,
  input  logic [CW-1:0]     win_width,
  input  logic [AW-1:0]     wptr,
  input  logic              rd_vld,
  input  logic [CHW-1:0]    rd_chan,
  input  logic [CW-1:0]     rd_coarse,
  input  logic [FW-1:0]     rd_fine,
  input  logic              word_ready,
  output logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] word,
  output logic              word_valid,
  output logic              busy,
  output logic              hit_ok,
  output logic [EVT_W-1:0]  evt_o
);

  localparam int PAY_W = WORD_W - 4;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  scan_state_e      state;
  logic [CW-1:0]    tbx_q;
  logic [AW-1:0]    idx;
  logic [CNT_W-1:0] cnt;
  logic [EVT_W-1:0] evt;

  // Window test in modulo coarse arithmetic
  function automatic logic in_window(input logic [CW-1:0] hbx, input logic [CW-1:0] tbx,
                                     input logic [CW-1:0] off, input logic [CW-1:0] wid);
    logic [CW-1:0] rel;
    rel = hbx + off - tbx;
    return rel < wid;
  endfunction

  assign rd_idx = wptr + idx;
  assign hit_ok = (state == SC_SCAN) && rd_vld &&
                  in_window(rd_coarse, tbx_q, win_offset, win_width);

  always_comb begin
    word       = '0;
    word_valid = 1'b0;
    case (state)
      SC_HEAD: begin
        word       = {KIND_HEAD, chip, PAY_W'(evt)};
        word_valid = 1'b1;
      end
      SC_SCAN: begin
        word       = {KIND_DATA, chip, rd_chan, rd_coarse, rd_fine};
        word_valid = hit_ok;
      end
      SC_TAIL: begin
        word       = {KIND_TAIL, chip, PAY_W'(cnt)};
        word_valid = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SC_IDLE;
      tbx_q <= '0;
      idx   <= '0;
      cnt   <= '0;
      evt   <= '0;
    end else begin
      case (state)
        SC_IDLE: if (trig) begin
          tbx_q <= trig_bx;
          idx   <= '0;
          cnt   <= '0;
          state <= SC_HEAD;
        end
        SC_HEAD: if (word_ready) state <= SC_SCAN;
        SC_SCAN: if (!hit_ok || word_ready) begin
          if (hit_ok) cnt <= cnt + CNT_W'(1);
          if (idx == LAST) state <= SC_TAIL;
          else idx <= idx + AW'(1);
        end
        SC_TAIL: if (word_ready) begin
          evt   <= evt + EVT_W'(1);
          state <= SC_IDLE;
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign busy  = (state != SC_IDLE);
  assign evt_o = evt;

endmodule

// File: rtl/tdc_word_shifter.sv
// Parallel-to-serial word output, MSB first, one idle cycle between words.
module tdc_word_shifter #(
  parameter int WORD_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              ser_data,
  output logic              ser_frame
);

  localparam int BW = $clog2(WORD_W);

  logic              active;
  logic [WORD_W-1:0] sh;
  logic [BW-1:0]     left;

  assign word_ready = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '0;
      left   <= '0;
    end else if (word_valid && !active) begin
      active <= 1'b1;
      sh     <= word;
      left   <= BW'(WORD_W - 1);
    end else if (active) begin
      sh <= sh << 1;
      if (left == '0) active <= 1'b0;
      else left <= left - BW'(1);
    end
  end

  assign ser_data  = active & sh[WORD_W-1];
  assign ser_frame = active;

endmodule

// File: rtl/tdc_match_core.sv
module tdc_match_core #(
  parameter int NCH   = 24,
  parameter int CW    = 12,
  parameter int DEPTH = 32,
  parameter int EVT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     bx_count,
  input  logic [NCH-1:0]    hit_valid,
  input  logic [NCH*5-1:0]  hit_fine,
  input  logic              trig_accept,
  input  logic [1:0]        chip_id,
  input  logic [CW-1:0]     win_offset,
  input  logic [CW-1:0]     win_width,
  output logic              ser_data,
  output logic              ser_frame
);

  localparam int FW     = 5;
  localparam int CHW    = $clog2(NCH);
  localparam int AW     = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int WORD_W = 4 + CHW + CW + FW;

  // Named internal events, observed by the bound checker
  logic              busy;
  logic              ring_we;
  logic [NCH-1:0]    pend;
  logic [NCH-1:0]    grant;
  logic              hit_ok;
  logic [EVT_W-1:0]  evt;
  logic              word_valid;
  logic              word_ready;

  logic [CHW-1:0]    w_chan;
  logic [CW-1:0]     w_coarse;
  logic [FW-1:0]     w_fine;
  logic [AW-1:0]     rd_idx;
  logic [AW-1:0]     wptr;
  logic              rd_vld;
  logic [CHW-1:0]    rd_chan;
  logic [CW-1:0]     rd_coarse;
  logic [FW-1:0]     rd_fine;
  logic [WORD_W-1:0] word;

  tdc_hit_capture #(.NCH(NCH), .CW(CW), .FW(FW), .CHW(CHW)) u_cap (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_fine(hit_fine),
    .bx(bx_count), .stall(busy), .wr_en(ring_we), .wr_chan(w_chan),
    .wr_coarse(w_coarse), .wr_fine(w_fine), .pend_o(pend), .grant_o(grant)
  );

  tdc_l1_ring #(.DEPTH(DEPTH), .CHW(CHW), .CW(CW), .FW(FW), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n), .we(ring_we), .w_chan(w_chan),
    .w_coarse(w_coarse), .w_fine(w_fine), .rd_idx(rd_idx), .rd_vld(rd_vld),
    .rd_chan(rd_chan), .rd_coarse(rd_coarse), .rd_fine(rd_fine), .wptr_o(wptr)
  );

  tdc_window_scan #(.CW(CW), .CHW(CHW), .FW(FW), .AW(AW), .DEPTH(DEPTH),
                    .EVT_W(EVT_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .trig(trig_accept), .trig_bx(bx_count),
    .chip(chip_id), .win_offset(win_offset), .win_width(win_width),
    .wptr(wptr), .rd_vld(rd_vld), .rd_chan(rd_chan), .rd_coarse(rd_coarse),
    .rd_fine(rd_fine), .word_ready(word_ready), .rd_idx(rd_idx), .word(word),
    .word_valid(word_valid), .busy(busy), .hit_ok(hit_ok), .evt_o(evt)
  );

  tdc_word_shifter #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .word(word), .word_valid(word_valid),
    .word_ready(word_ready), .ser_data(ser_data), .ser_frame(ser_frame)
  );

endmodule

// File: rtl/tdc_match_chk.sv
module tdc_match_chk #(
  parameter int NCH    = 24,
  parameter int WORD_W = 26,
  parameter int EVT_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             busy,
  input logic [EVT_W-1:0] evt,
  input logic [NCH-1:0]   grant,
  input logic [NCH-1:0]   pend,
  input logic             ring_we,
  input logic             word_valid,
  input logic             word_ready,
  input logic             ser_frame
);

  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else run <= ser_frame ? run + 16'd1 : 16'd0;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7

  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ring_we); // R10

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~grant)) |=> ((($past(pend) & ~$past(grant)) & ~pend) == '0)); // R8

  AST_START_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig)); // R9

  AST_EVT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt) |-> $fell(busy)); // R6

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> word_valid); // R4

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_frame && run != 16'd0) |-> (run == 16'(WORD_W))); // R12

endmodule

bind tdc_match_core tdc_match_chk #(.NCH(NCH), .WORD_W(WORD_W), .EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig_accept), .busy(busy), .evt(evt),
  .grant(grant), .pend(pend), .ring_we(ring_we), .word_valid(word_valid),
  .word_ready(word_ready), .ser_frame(ser_frame)
);

// File: tb/sim_tdc_match_core.sv
`timescale 1ns/1ps
module sim_tdc_match_core;

  localparam int NCH = 24, CW = 6, DEPTH = 8, EVT_W = 8, FW = 5;
  localparam int WORD_W = 4 + 5 + CW + FW;

  // hit bx, trigger bx, offset, width, expect match
  localparam int VT [8][5] = '{
    '{10, 20, 12, 4, 1},
    '{10, 20,  9, 4, 0},
    '{10, 20, 13, 4, 1},
    '{10, 20, 14, 4, 0},
    '{60,  5, 10, 3, 1},
    '{62,  2,  4, 1, 1},
    '{62,  2,  4, 0, 0},
    '{30, 30,  0, 1, 1}
  };

  logic              clk = 0;
  logic              rst_n = 0;
  logic [CW-1:0]     bx_count = '0;
  logic [NCH-1:0]    hit_valid = '0;
  logic [NCH*5-1:0]  hit_fine = '0;
  logic              trig_accept = 0;
  logic [1:0]        chip_id = 2'd1;
  logic [CW-1:0]     win_offset = '0;
  logic [CW-1:0]     win_width = '0;
  logic              ser_data, ser_frame;

  int checks = 0, errors = 0, frame_errs = 0;
  int rx_n = 0, base = 0, run = 0;
  bit done = 0;
  logic [WORD_W-1:0] acc = '0;
  logic [WORD_W-1:0] rxw [0:1023];

  always #4 clk = ~clk;

  tdc_match_core #(.NCH(NCH), .CW(CW), .DEPTH(DEPTH), .EVT_W(EVT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bx_count(bx_count), .hit_valid(hit_valid),
    .hit_fine(hit_fine), .trig_accept(trig_accept), .chip_id(chip_id),
    .win_offset(win_offset), .win_width(win_width),
    .ser_data(ser_data), .ser_frame(ser_frame)
  );

  // Serial receiver, also checks word framing (R12)
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0;
    end else if (ser_frame) begin
      acc = {acc[WORD_W-2:0], ser_data};
      run = run + 1;
      if (run == WORD_W) begin
        rxw[rx_n] = acc;
        rx_n = rx_n + 1;
      end
    end else begin
      if (run != 0 && run != WORD_W) frame_errs = frame_errs + 1;
      run = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] dword(input int chip, input int ch, input int c, input int f);
    return {2'b00, 2'(chip), 5'(ch), 6'(c), 5'(f)};
  endfunction
  function automatic logic [WORD_W-1:0] hword(input int chip, input int e);
    return {2'b10, 2'(chip), 16'(e)};
  endfunction
  function automatic logic [WORD_W-1:0] tword(input int chip, input int n);
    return {2'b11, 2'(chip), 16'(n)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; hit_valid = '0; trig_accept = 0;
    tick(3);
    chk("R1", "frame in reset", 32'(ser_frame), 0);
    rst_n = 1;
    tick(2);
  endtask

  task automatic pulse_hit(input int ch, input int f, input int b);
    bx_count = CW'(b);
    hit_valid[ch] = 1'b1;
    hit_fine[ch*FW +: FW] = FW'(f);
    @(negedge clk);
    hit_valid = '0;
  endtask

  task automatic fire(input int b);
    bx_count = CW'(b);
    trig_accept = 1;
    @(negedge clk);
    trig_accept = 0;
  endtask

  task automatic wait_rx(input int n);
    int t;
    t = 0;
    while ((rx_n - base) < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    tick(60);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: idle after reset, no output without a trigger
    do_reset();
    base = rx_n;
    tick(50);
    chk("R1", "words without trigger", 32'(rx_n - base), 0);

    // Table: window edges, expiry, wrap, zero width (R2, R3)
    for (int v = 0; v < 8; v++) begin
      do_reset();
      chip_id = 2'd1;
      win_offset = CW'(VT[v][2]);
      win_width  = CW'(VT[v][3]);
      pulse_hit(9, v + 1, VT[v][0]);
      tick(3);
      base = rx_n;
      fire(VT[v][1]);
      wait_rx(VT[v][4] ? 3 : 2);
      chk("R1", "first header", 32'(rxw[base]), 32'(hword(1, 0)));
      if (VT[v][4] != 0) begin
        chk("R2", "matched count", 32'(rx_n - base), 3);
        chk("R2", "matched data", 32'(rxw[base+1]), 32'(dword(1, 9, VT[v][0], v + 1)));
        chk("R2", "trailer", 32'(rxw[base+2]), 32'(tword(1, 1)));
      end else begin
        chk("R3", "unmatched count", 32'(rx_n - base), 2);
        chk("R3", "empty trailer", 32'(rxw[base+1]), 32'(tword(1, 0)));
      end
    end

    // Same-cycle hits: ascending order, chip id, fine code (R4 R5 R7 R13)
    do_reset();
    chip_id = 2'd2; win_offset = 6'd5; win_width = 6'd6;
    bx_count = 6'd10;
    hit_valid[20] = 1; hit_fine[20*FW +: FW] = 5'd11;
    hit_valid[3]  = 1; hit_fine[3*FW +: FW]  = 5'd22;
    hit_valid[7]  = 1; hit_fine[7*FW +: FW]  = 5'd3;
    @(negedge clk);
    hit_valid = '0;
    tick(5);
    base = rx_n;
    fire(12);
    wait_rx(5);
    chk("R4", "packet length", 32'(rx_n - base), 5);
    chk("R5", "header chip", 32'(rxw[base]), 32'(hword(2, 0)));
    chk("R7", "first data ch3", 32'(rxw[base+1]), 32'(dword(2, 3, 10, 22)));
    chk("R7", "second data ch7", 32'(rxw[base+2]), 32'(dword(2, 7, 10, 3)));
    chk("R13", "third data ch20", 32'(rxw[base+3]), 32'(dword(2, 20, 10, 11)));
    chk("R4", "trailer count", 32'(rxw[base+4]), 32'(tword(2, 3)));

    // Event number advances; hits stay after readout (R6, R2)
    base = rx_n;
    fire(12);
    wait_rx(5);
    chk("R6", "second header", 32'(rxw[base]), 32'(hword(2, 1)));
    chk("R2", "hits kept", 32'(rxw[base+4]), 32'(tword(2, 3)));

    // Trigger and hits during a packet (R8, R9, R10)
    base = rx_n;
    fire(12);
    bx_count = 6'd13;
    trig_accept = 1;
    hit_valid[5] = 1; hit_fine[5*FW +: FW] = 5'd1;
    @(negedge clk);
    trig_accept = 0;
    hit_fine[5*FW +: FW] = 5'd2;
    @(negedge clk);
    hit_valid = '0;
    wait_rx(5);
    chk("R9", "one packet only", 32'(rx_n - base), 5);
    chk("R6", "third header", 32'(rxw[base]), 32'(hword(2, 2)));
    tick(5);
    base = rx_n;
    fire(14);
    wait_rx(6);
    chk("R9", "event not advanced by ignored trigger", 32'(rxw[base]), 32'(hword(2, 3)));
    chk("R10", "held hit stored last", 32'(rxw[base+4]), 32'(dword(2, 5, 13, 1)));
    chk("R8", "second hit dropped", 32'(rxw[base+5]), 32'(tword(2, 4)));

    // Overflow: ten hits into eight slots (R11)
    do_reset();
    chip_id = 2'd0; win_offset = 6'd20; win_width = 6'd20;
    for (int i = 0; i < 10; i++) pulse_hit(i, i, 20 + i);
    tick(3);
    base = rx_n;
    fire(30);
    wait_rx(10);
    chk("R11", "packet length", 32'(rx_n - base), 10);
    for (int j = 0; j < 8; j++)
      chk("R11", "surviving hit", 32'(rxw[base+1+j]), 32'(dword(0, j + 2, 22 + j, j + 2)));
    chk("R11", "trailer", 32'(rxw[base+9]), 32'(tword(0, 8)));

    chk("R12", "framing errors", 32'(frame_errs), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule